// File: doc/BRIEF.md
# Cadenced Tone Generator Controller

This block turns a digital two-pole resonator into a source of cadenced tones: bursts of sine samples separated by silent gaps. Every advance of the oscillator and of the cadence timing happens on a one-cycle strobe that marks the 8 kHz sample instant. A register write port programs the frequency coefficient, the starting amplitude, the burst length and the gap length, and a control word sets the generator enable, the timer enables, the zero-crossing end rule, the path routing and the interrupt enables.

While enabled, the block cycles from idle to burst to gap to burst again. Each burst reloads the oscillator so every burst starts with the same waveform. The end of a burst and the end of a gap each set a sticky pending flag, and enabled flags drive a combined interrupt line. Each sample comes with a valid pulse, plus per-path valid flags for the transmit and receive directions.

Register map (word address on `wr_addr_i`): 0 control, 1 coefficient, 2 amplitude, 3 burst length, 4 gap length, 5 pending-flag clear. Control bits: 0 generator enable, 1 burst timer enable, 2 gap timer enable, 3 zero-cross end rule, 4 route to transmit, 5 route to receive, 6 burst-end interrupt enable, 7 gap-end interrupt enable.

Top module: `tone_cadence_gen`

## Requirements
- R1: After reset `sample_o`, `sample_vld_o`, `tx_vld_o`, `rx_vld_o`, `irq_o` and `irq_status_o` are all zero.
- R2: `sample_vld_o` is high for exactly the one clock after each `tick_i` pulse taken while control bit 0 is set, and stays low for ticks taken while it is clear.
- R3: The first sample of a burst equals the amplitude register. Each later sample is y[n] = sat16(floor(coef*y[n-1] / 2^13) - y[n-2]), with a signed Q1.14 coefficient, y[n-2] of the first step taken as zero, and saturation to [-32768, 32767].
- R4: With both timers enabled, a burst emits max(L,1) samples, where L is the burst length, and the gap then emits max(G,1) zero samples, where G is the gap length. The next burst then starts with a reload.
- R5: With the burst timer disabled the tone runs without end. With the gap timer disabled a burst is followed by a gap that lasts until the generator is disabled.
- R6: With the zero-cross rule set, an expired burst keeps producing samples until a sample's sign bit differs from the previous sample's. That sample is emitted as zero and is the first sample of the gap.
- R7: The end of a timed burst sets pending bit 0 and the end of a timed gap sets pending bit 1. Both bits are sticky and appear on `irq_status_o`. `irq_o` is the OR of each pending bit ANDed with its enable (control bit 6 for bit 0, bit 7 for bit 1).
- R8: Writing address 5 clears each pending bit whose data bit is 1. An expiry in the same cycle as the clear leaves that bit set.
- R9: `tx_vld_o` equals `sample_vld_o` AND control bit 4. `rx_vld_o` equals `sample_vld_o` AND control bit 5.
- R10: Clearing control bit 0 forces `sample_o` to zero from the next clock. A later re-enable starts a fresh burst, with a reload, on the next tick.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| tick_i | input | 1 | One-cycle sample strobe (8 kHz) |
| wr_en_i | input | 1 | Register write strobe |
| wr_addr_i | input | 3 | Register word address |
| wr_data_i | input | WD (16) | Register write data |
| sample_o | output | DW (16) | Signed output sample |
| sample_vld_o | output | 1 | Sample valid, one clock per tick |
| tx_vld_o | output | 1 | Sample valid toward the transmit path |
| rx_vld_o | output | 1 | Sample valid toward the receive path |
| irq_o | output | 1 | Combined interrupt request |
| irq_status_o | output | 2 | Pending flags: bit 0 burst end, bit 1 gap end |

## Verification
The bench sweeps burst and gap lengths from zero to small values. A design that uses a length of zero literally would stall forever or emit one sample too many or too few, and the tick-by-tick sample compare catches either. Zero-cross runs use a six-sample waveform whose zero samples count as positive, so a sign test that treats zero as a sign change ends the burst early. A high-amplitude run with a near-unity coefficient exposes wrap-around where saturation is required. A clear written in the same cycle as an expiry shows whether the set wins. Disabling mid-burst and re-enabling shows whether the oscillator state carries over instead of being reloaded.

// File: rtl/tcg_pkg.sv
package tcg_pkg;
  localparam int AW = 3;

  localparam int A_CTRL  = 0;
  localparam int A_COEF  = 1;
  localparam int A_AMP   = 2;
  localparam int A_BLEN  = 3;
  localparam int A_GLEN  = 4;
  localparam int A_CLR   = 5;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_BURST = 2'd1,
    ST_DRAIN = 2'd2,
    ST_GAP   = 2'd3
  } cad_state_e;

  // bit 0 is gen_en
  typedef struct packed {
    logic irq_en_gap;
    logic irq_en_burst;
    logic route_rx;
    logic route_tx;
    logic zc_en;
    logic gap_tmr_en;
    logic burst_tmr_en;
    logic gen_en;
  } ctrl_t;
endpackage

// File: rtl/tcg_regs.sv
module tcg_regs
  import tcg_pkg::*;
#(
  parameter int DW = 16,
  parameter int CW = 16,
  parameter int WD = 16
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 wr_en_i,
  input  logic [AW-1:0]        wr_addr_i,
  input  logic [WD-1:0]        wr_data_i,
  output ctrl_t                ctrl_o,
  output logic signed [DW-1:0] coef_o,
  output logic signed [DW-1:0] amp_o,
  output logic [CW-1:0]        blen_o,
  output logic [CW-1:0]        glen_o,
  output logic [1:0]           clr_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ctrl_o <= '0;
      coef_o <= '0;
      amp_o  <= '0;
      blen_o <= '0;
      glen_o <= '0;
    end else if (wr_en_i) begin
      unique case (wr_addr_i)
        AW'(A_CTRL): ctrl_o <= ctrl_t'(wr_data_i[7:0]);
        AW'(A_COEF): coef_o <= wr_data_i[DW-1:0];
        AW'(A_AMP):  amp_o  <= wr_data_i[DW-1:0];
        AW'(A_BLEN): blen_o <= wr_data_i[CW-1:0];
        AW'(A_GLEN): glen_o <= wr_data_i[CW-1:0];
        default: ;
      endcase
    end
  end

  assign clr_o = (wr_en_i && wr_addr_i == AW'(A_CLR)) ? wr_data_i[1:0] : 2'b00;
endmodule

// File: rtl/tcg_osc.sv
module tcg_osc #(
  parameter int DW   = 16,
  parameter int FRAC = 14
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 load_i,
  input  logic                 zero_i,
  input  logic                 adv_i,
  input  logic signed [DW-1:0] coef_i,
  input  logic signed [DW-1:0] amp_i,
  output logic signed [DW-1:0] y_o,
  output logic signed [DW-1:0] y_nxt_o
);
  localparam int PW = 2 * DW;
  localparam int XW = PW + 1;
  localparam logic signed [XW-1:0] HI = XW'((2 ** (DW - 1)) - 1);
  localparam logic signed [XW-1:0] LO = -HI - XW'(1);

  logic signed [DW-1:0] y1_q, y2_q;
  logic signed [PW-1:0] prod;
  logic signed [PW-1:0] scaled;
  logic signed [XW-1:0] acc;

  // 2*coef*y with coef in Q1.14 -> shift by FRAC-1
  assign prod   = coef_i * y1_q;
  assign scaled = prod >>> (FRAC - 1);
  assign acc    = $signed({scaled[PW-1], scaled})
                - $signed({{(XW - DW){y2_q[DW-1]}}, y2_q});

  always_comb begin
    if (acc > HI)      y_nxt_o = HI[DW-1:0];
    else if (acc < LO) y_nxt_o = LO[DW-1:0];
    else               y_nxt_o = acc[DW-1:0];
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      y1_q <= '0;
      y2_q <= '0;
    end else if (zero_i) begin
      y1_q <= '0;
      y2_q <= '0;
    end else if (load_i) begin
      y1_q <= amp_i;
      y2_q <= '0;
    end else if (adv_i) begin
      y2_q <= y1_q;
      y1_q <= y_nxt_o;
    end
  end

  assign y_o = y1_q;
endmodule

// File: rtl/tcg_cadence.sv
module tcg_cadence
  import tcg_pkg::*;
#(
  parameter int CW = 16
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          tick_i,
  input  logic          gen_en_i,
  input  logic          burst_tmr_en_i,
  input  logic          gap_tmr_en_i,
  input  logic          zc_en_i,
  input  logic [CW-1:0] blen_i,
  input  logic [CW-1:0] glen_i,
  input  logic          sign_cur_i,
  input  logic          sign_nxt_i,
  output cad_state_e    state_o,
  output logic          load_o,
  output logic          zero_o,
  output logic          adv_o,
  output logic          burst_exp_o,
  output logic          gap_exp_o
);
  cad_state_e    state_q, state_d;
  logic [CW-1:0] cnt_q, cnt_d;
  logic [CW-1:0] blast, glast;
  logic          crossing, may_end;

  // zero length behaves as one tick
  assign blast    = (blen_i == '0) ? '0 : blen_i - CW'(1);
  assign glast    = (glen_i == '0) ? '0 : glen_i - CW'(1);
  assign crossing = sign_cur_i ^ sign_nxt_i;
  assign may_end  = !zc_en_i || crossing;

  always_comb begin
    state_d     = state_q;
    cnt_d       = cnt_q;
    load_o      = 1'b0;
    zero_o      = 1'b0;
    adv_o       = 1'b0;
    burst_exp_o = 1'b0;
    gap_exp_o   = 1'b0;
    if (!gen_en_i) begin
      state_d = ST_IDLE;
      cnt_d   = '0;
      zero_o  = 1'b1;
    end else if (tick_i) begin
      unique case (state_q)
        ST_IDLE: begin
          state_d = ST_BURST;
          cnt_d   = '0;
          load_o  = 1'b1;
        end
        ST_BURST: begin
          burst_exp_o = burst_tmr_en_i && (cnt_q == blast);
          if (burst_exp_o) begin
            if (may_end) begin
              state_d = ST_GAP;
              cnt_d   = '0;
              zero_o  = 1'b1;
            end else begin
              state_d = ST_DRAIN;
              adv_o   = 1'b1;
            end
          end else begin
            cnt_d = cnt_q + CW'(1);
            adv_o = 1'b1;
          end
        end
        ST_DRAIN: begin
          if (may_end) begin
            state_d = ST_GAP;
            cnt_d   = '0;
            zero_o  = 1'b1;
          end else begin
            adv_o = 1'b1;
          end
        end
        ST_GAP: begin
          gap_exp_o = gap_tmr_en_i && (cnt_q == glast);
          if (gap_exp_o) begin
            state_d = ST_BURST;
            cnt_d   = '0;
            load_o  = 1'b1;
          end else begin
            cnt_d = cnt_q + CW'(1);
          end
        end
        default: state_d = ST_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      cnt_q   <= '0;
    end else begin
      state_q <= state_d;
      cnt_q   <= cnt_d;
    end
  end

  assign state_o = state_q;
endmodule

// File: rtl/tcg_irq.sv
module tcg_irq #(
  parameter int N = 2
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [N-1:0] set_i,
  input  logic [N-1:0] clr_i,
  input  logic [N-1:0] en_i,
  output logic [N-1:0] pend_o,
  output logic         irq_o
);
  for (genvar g = 0; g < N; g++) begin : g_pend
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)       pend_o[g] <= 1'b0;
      else if (set_i[g]) pend_o[g] <= 1'b1;   // set beats clear
      else if (clr_i[g]) pend_o[g] <= 1'b0;
    end
  end

  assign irq_o = |(pend_o & en_i);
endmodule

// File: rtl/tone_cadence_gen.sv
module tone_cadence_gen
  import tcg_pkg::*;
#(
  parameter int DW   = 16,
  parameter int CW   = 16,
  parameter int FRAC = 14,
  localparam int WD  = (DW > CW) ? ((DW > 8) ? DW : 8) : ((CW > 8) ? CW : 8)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          tick_i,
  input  logic          wr_en_i,
  input  logic [AW-1:0] wr_addr_i,
  input  logic [WD-1:0] wr_data_i,
  output logic [DW-1:0] sample_o,
  output logic          sample_vld_o,
  output logic          tx_vld_o,
  output logic          rx_vld_o,
  output logic          irq_o,
  output logic [1:0]    irq_status_o
);
  ctrl_t                ctrl;
  logic signed [DW-1:0] coef, amp;
  logic [CW-1:0]        blen, glen;
  logic [1:0]           clr_pulse;
  cad_state_e           cad_state;
  logic                 osc_load, osc_zero, osc_adv;
  logic                 burst_exp, gap_exp;
  logic signed [DW-1:0] osc_y, osc_nxt;
  logic                 vld_q;

  tcg_regs #(.DW(DW), .CW(CW), .WD(WD)) i_regs (
    .clk_i, .rst_ni, .wr_en_i, .wr_addr_i, .wr_data_i,
    .ctrl_o(ctrl), .coef_o(coef), .amp_o(amp),
    .blen_o(blen), .glen_o(glen), .clr_o(clr_pulse)
  );

  tcg_cadence #(.CW(CW)) i_cadence (
    .clk_i, .rst_ni, .tick_i,
    .gen_en_i(ctrl.gen_en),
    .burst_tmr_en_i(ctrl.burst_tmr_en),
    .gap_tmr_en_i(ctrl.gap_tmr_en),
    .zc_en_i(ctrl.zc_en),
    .blen_i(blen), .glen_i(glen),
    .sign_cur_i(osc_y[DW-1]), .sign_nxt_i(osc_nxt[DW-1]),
    .state_o(cad_state),
    .load_o(osc_load), .zero_o(osc_zero), .adv_o(osc_adv),
    .burst_exp_o(burst_exp), .gap_exp_o(gap_exp)
  );

  tcg_osc #(.DW(DW), .FRAC(FRAC)) i_osc (
    .clk_i, .rst_ni,
    .load_i(osc_load), .zero_i(osc_zero), .adv_i(osc_adv),
    .coef_i(coef), .amp_i(amp),
    .y_o(osc_y), .y_nxt_o(osc_nxt)
  );

  tcg_irq #(.N(2)) i_irq (
    .clk_i, .rst_ni,
    .set_i({gap_exp, burst_exp}),
    .clr_i(clr_pulse),
    .en_i({ctrl.irq_en_gap, ctrl.irq_en_burst}),
    .pend_o(irq_status_o),
    .irq_o
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) vld_q <= 1'b0;
    else         vld_q <= tick_i && ctrl.gen_en;
  end

  assign sample_o = (ctrl.gen_en && (cad_state == ST_BURST || cad_state == ST_DRAIN))
                  ? osc_y : '0;
  assign sample_vld_o = vld_q;
  assign tx_vld_o     = vld_q && ctrl.route_tx;
  assign rx_vld_o     = vld_q && ctrl.route_rx;
endmodule

// File: rtl/tcg_checker.sv
module tcg_checker
  import tcg_pkg::*;
#(
  parameter int DW = 16,
  parameter int WD = 16
) (
  input logic                 clk_i,
  input logic                 rst_ni,
  input logic                 tick_i,
  input logic                 wr_en_i,
  input logic [AW-1:0]        wr_addr_i,
  input logic [WD-1:0]        wr_data_i,
  input logic [DW-1:0]        sample_o,
  input logic                 sample_vld_o,
  input logic                 tx_vld_o,
  input logic                 rx_vld_o,
  input logic                 irq_o,
  input logic [1:0]           irq_status_o,
  input cad_state_e           cad_state,
  input logic                 osc_load,
  input logic signed [DW-1:0] osc_y,
  input logic signed [DW-1:0] amp
);
  logic clr0;
  assign clr0 = wr_en_i && (wr_addr_i == AW'(A_CLR)) && wr_data_i[0];

  p_vld_after_tick_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sample_vld_o |-> $past(tick_i));

  p_route_subset_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tx_vld_o || rx_vld_o) |-> sample_vld_o);

  p_reload_amp_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    osc_load |=> (osc_y == $past(amp)));

  p_irq_has_source_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_o |-> (irq_status_o != 2'b00));

  p_pend_rise_on_tick_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(irq_status_o[0]) |-> $past(tick_i));

  p_pend_sticky_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (irq_status_o[0] && !clr0) |=> irq_status_o[0]);

  p_idle_silent_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cad_state == ST_IDLE) |-> (sample_o == '0));
endmodule

bind tone_cadence_gen tcg_checker #(.DW(DW), .WD(WD)) i_tcg_checker (
  .clk_i, .rst_ni, .tick_i, .wr_en_i, .wr_addr_i, .wr_data_i,
  .sample_o, .sample_vld_o, .tx_vld_o, .rx_vld_o, .irq_o, .irq_status_o,
  .cad_state(cad_state), .osc_load(osc_load), .osc_y(osc_y), .amp(amp)
);

// File: tb/test_tone_cadence_gen.sv
`timescale 1ns/1ps
module test_tone_cadence_gen;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        tick_i = 1'b0;
  logic        wr_en_i = 1'b0;
  logic [2:0]  wr_addr_i = '0;
  logic [15:0] wr_data_i = '0;
  logic [15:0] sample_o;
  logic        sample_vld_o, tx_vld_o, rx_vld_o, irq_o;
  logic [1:0]  irq_status_o;

  int n_chk = 0;
  int n_err = 0;

  // reference model state
  logic [7:0]         m_ctrl = '0;
  logic signed [15:0] m_coef = '0, m_amp = '0;
  logic [15:0]        m_bl = '0, m_gl = '0, m_cnt = '0;
  int                 m_st = 0;
  logic signed [15:0] m_y1 = '0, m_y2 = '0;
  logic [1:0]         m_pend = '0;
  logic               m_vld = 1'b0;

  always #2.5 clk_i = ~clk_i;

  tone_cadence_gen i_tone_cadence_gen (
    .clk_i, .rst_ni, .tick_i, .wr_en_i, .wr_addr_i, .wr_data_i,
    .sample_o, .sample_vld_o, .tx_vld_o, .rx_vld_o, .irq_o, .irq_status_o
  );

  task automatic chk(input bit ok, input string req, input string what,
                     input longint act, input longint exp);
    n_chk++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  function automatic logic signed [15:0] f_next(logic signed [15:0] c,
                                                logic signed [15:0] a,
                                                logic signed [15:0] b);
    longint p, s;
    p = longint'(c) * longint'(a);
    s = (p >>> 13) - longint'(b);
    if (s > 32767)  s = 32767;
    if (s < -32768) s = -32768;
    return 16'(s);
  endfunction

  task automatic m_reload();
    m_st = 1; m_cnt = '0; m_y1 = m_amp; m_y2 = '0;
  endtask

  task automatic m_try_end(input logic signed [15:0] nx);
    if (!m_ctrl[3] || (nx[15] != m_y1[15])) begin
      m_st = 3; m_cnt = '0; m_y1 = '0; m_y2 = '0;
    end else begin
      m_st = 2; m_y2 = m_y1; m_y1 = nx;
    end
  endtask

  task automatic m_step();
    logic signed [15:0] nx;
    logic [15:0] bl1, gl1;
    m_vld = m_ctrl[0];
    if (!m_ctrl[0]) return;
    bl1 = (m_bl == 0) ? 16'd0 : m_bl - 16'd1;
    gl1 = (m_gl == 0) ? 16'd0 : m_gl - 16'd1;
    nx  = f_next(m_coef, m_y1, m_y2);
    case (m_st)
      0: m_reload();
      1: if (m_ctrl[1] && m_cnt == bl1) begin
           m_pend[0] = 1'b1;
           m_try_end(nx);
         end else begin
           m_cnt++; m_y2 = m_y1; m_y1 = nx;
         end
      2: m_try_end(nx);
      default:
         if (m_ctrl[2] && m_cnt == gl1) begin
           m_pend[1] = 1'b1;
           m_reload();
         end else m_cnt++;
    endcase
  endtask

  task automatic check_out(input string tag);
    logic signed [15:0] es;
    es = (m_ctrl[0] && (m_st == 1 || m_st == 2)) ? m_y1 : 16'sd0;
    chk($signed(sample_o) == es, tag, "sample", $signed(sample_o), es);
    chk(sample_vld_o == m_vld, "R2", "sample valid", sample_vld_o, m_vld);
    chk(tx_vld_o == (m_vld & m_ctrl[4]), "R9", "tx valid", tx_vld_o, m_vld & m_ctrl[4]);
    chk(rx_vld_o == (m_vld & m_ctrl[5]), "R9", "rx valid", rx_vld_o, m_vld & m_ctrl[5]);
    chk(irq_status_o == m_pend, "R7", "pending", irq_status_o, m_pend);
    chk(irq_o == |(m_pend & m_ctrl[7:6]), "R7", "irq", irq_o, |(m_pend & m_ctrl[7:6]));
  endtask

  task automatic wr(input int a, input int d);
    @(negedge clk_i);
    wr_en_i = 1'b1; wr_addr_i = 3'(a); wr_data_i = 16'(d);
    @(negedge clk_i);
    wr_en_i = 1'b0;
    case (a)
      0: begin
           m_ctrl = 8'(d);
           if (!m_ctrl[0]) begin m_st = 0; m_cnt = '0; m_y1 = '0; m_y2 = '0; end
         end
      1: m_coef = 16'(d);
      2: m_amp  = 16'(d);
      3: m_bl   = 16'(d);
      4: m_gl   = 16'(d);
      5: m_pend = m_pend & ~2'(d);
      default: ;
    endcase
    m_vld = 1'b0;
  endtask

  task automatic ticks(input string tag, input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk_i); tick_i = 1'b1;
      @(negedge clk_i); tick_i = 1'b0;
      m_step();
      check_out(tag);
    end
  endtask

  task automatic tick_clr(input int d);
    @(negedge clk_i);
    tick_i = 1'b1; wr_en_i = 1'b1; wr_addr_i = 3'd5; wr_data_i = 16'(d);
    @(negedge clk_i);
    tick_i = 1'b0; wr_en_i = 1'b0;
    m_pend = m_pend & ~2'(d);
    m_step();
    chk(irq_status_o == m_pend, "R8", "set beats clear", irq_status_o, m_pend);
    check_out("R8");
  endtask

  initial begin
    #(5ns * 150000);
    n_err++;
    $display("FAIL watchdog expired");
    $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk_i);
    rst_ni = 1'b1;
    @(negedge clk_i);
    check_out("R1");

    // basic cadence, six-sample waveform
    wr(1, 8192); wr(2, 1000);
    wr(3, 4); wr(4, 3);
    wr(0, 8'hF7);
    ticks("R4", 20);
    wr(5, 3);
    check_out("R8");

    // length sweep including zero
    for (int b = 0; b < 4; b++) begin
      for (int g = 0; g < 3; g++) begin
        wr(3, b); wr(4, g);
        wr(0, 8'h37);
        ticks("R4", 12);
        wr(0, 0);
        @(negedge clk_i);
        check_out("R10");
        wr(5, 3);
      end
    end

    // ticks while disabled
    ticks("R2", 3);

    // saturation and a general tone, continuous
    wr(1, 16383); wr(2, 30000);
    wr(0, 8'h11);
    ticks("R3", 8);
    wr(0, 0);
    wr(1, 12000); wr(2, -5000);
    wr(0, 8'h21);
    ticks("R3", 14);
    wr(0, 0);

    // continuous tone, then one-shot burst
    wr(1, 8192); wr(2, 1000);
    wr(3, 2); wr(4, 1);
    wr(0, 8'h31);
    ticks("R5", 10);
    wr(0, 0);
    wr(0, 8'h13);
    ticks("R5", 10);
    wr(0, 0);

    // zero-cross end rule
    for (int b = 0; b < 4; b++) begin
      wr(3, b); wr(4, 2);
      wr(0, 8'h1F);
      ticks("R6", 16);
      wr(0, 0);
    end
    wr(2, -700); wr(3, 2);
    wr(0, 8'h2F);
    ticks("R6", 16);
    wr(0, 0);
    wr(5, 3);

    // routing
    wr(2, 1000);
    for (int r = 0; r < 4; r++) begin
      wr(0, 8'h01 | (r << 4));
      ticks("R9", 3);
    end
    wr(0, 0);

    // interrupt gating, sticky, clear priority
    wr(3, 1); wr(4, 1);
    wr(0, 8'h47);
    ticks("R7", 4);
    wr(0, 8'h87);
    ticks("R7", 2);
    wr(5, 1);
    check_out("R8");
    wr(0, 8'hC7);
    ticks("R7", 1);
    tick_clr(1);
    tick_clr(2);
    wr(5, 3);
    check_out("R8");
    wr(0, 0);

    // disable mid-burst, re-enable reloads
    wr(3, 8); wr(4, 2);
    wr(0, 8'h37);
    ticks("R10", 3);
    wr(0, 0);
    chk(sample_o == 16'd0, "R10", "zero after disable", sample_o, 0);
    @(negedge clk_i);
    check_out("R10");
    wr(0, 8'h37);
    ticks("R10", 4);

    $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    $finish;
  end
endmodule